// File: doc/BRIEF.md
# Lock-Line Reservation Unit

This unit gives a core atomic read-modify-write on 128-byte lines. A load-and-reserve command reads a line from memory and streams it back to the core. It also records a reservation made of the requester's owner tag, the line index and a private copy of the line. A conditional store writes the line only if the same owner still holds a reservation on the same line. An unconditional store always writes the line and drops any reservation whose byte range it overlaps. Every command leaves a two-bit result code in a one-entry status channel.

Memory sits behind a 128-bit beat port. Each line moves as eight 16-byte beats, one beat per cycle, and read data returns one cycle after the request. The core supplies store data beat by beat: the unit presents a beat index and takes the data in the same cycle. Other agents that write memory report this through an invalidate input that carries a line index.

Top module: `lockline_resv_unit`

## Requirements
- R1: Commands and invalidates name a line index (a byte address divided by 128). A transfer is eight beats, issued one per cycle in beat order 0 to 7. Each beat address is the line index followed by the 3-bit beat number.
- R2: Load-and-reserve (op 0) returns the eight beats on the load port in beat order, with memory data one cycle after each request. It records a reservation for the requester's owner and line, then pushes code 0.
- R3: A conditional store (op 1) succeeds when a reservation is held and both its owner and its line equal the request. It pushes code 1 and writes only the beats whose store data differs from the reserved copy.
- R4: A conditional store that does not succeed pushes code 2 and issues no memory request.
- R5: A conditional store from the reservation's owner clears the reservation, whether it succeeds or fails. A conditional store from any other owner leaves the reservation in place.
- R6: An unconditional store (op 2) writes all eight beats and pushes code 3.
- R7: An unconditional store whose 128-byte range overlaps the reserved range clears the reservation. A store to another line leaves it in place.
- R8: The status channel holds one code. A newer code replaces an unread one.
- R9: An invalidate whose line equals the reserved line clears the reservation, and an invalidate on another line has no effect. If an invalidate arrives in the same cycle that a load-and-reserve is accepted, the new reservation is kept.
- R10: A pop while a code is present empties the channel. While the channel is empty, stat_valid is low and the reader waits, and a pop has no effect.
- R11: cmd_ready is high only when no command is in flight. Op 3 is accepted, pushes no code and changes nothing. A new load-and-reserve replaces any earlier reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 load-reserve, 1 conditional store, 2 unconditional store, 3 no-op |
| cmd_owner | input | OWNER_W | Requester tag |
| cmd_line | input | LINE_W | Line index |
| st_idx | output | IDX_W | Beat number whose store data is wanted |
| st_data | input | DATA_W | Store data for beat st_idx, same cycle |
| ld_valid | output | 1 | Load beat present |
| ld_idx | output | IDX_W | Beat number of ld_data |
| ld_data | output | DATA_W | Load beat data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | LINE_W+IDX_W | Beat address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after a read request |
| inv_valid | input | 1 | External invalidate |
| inv_line | input | LINE_W | Line index written by another agent |
| stat_pop | input | 1 | Read and empty the status channel |
| stat_valid | output | 1 | A code is present |
| stat_code | output | 2 | Result code |

## Verification
Some rules are checked by assertions on every cycle. These cover how the reservation register reacts to a load, to an owned conditional store, to an overlapping unconditional store and to an invalidate on the reserved line. They also cover the absence of a memory request after a failed conditional store, the all-beat write of an unconditional store, and the status channel's push and pop behaviour. Other results depend on a whole sequence of commands, and only the bench's scenarios can show them. These include which beats a successful conditional store skips, whether a reservation survives a store to another line or a non-owner's attempt, the order and content of returned beats, and a code being overwritten before it is read.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_RSV   = 2'd0,
    OP_STORE_COND = 2'd1,
    OP_STORE_ANY  = 2'd2,
    OP_NOP        = 2'd3
  } lr_op_e;

  typedef enum logic [1:0] {
    RC_GET_OK    = 2'd0,
    RC_COND_OK   = 2'd1,
    RC_COND_FAIL = 2'd2,
    RC_ANY_OK    = 2'd3
  } lr_code_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RD     = 2'd1,
    SQ_RDWAIT = 2'd2,
    SQ_WR     = 2'd3
  } lr_seq_e;
endpackage

// File: rtl/lr_resv.sv
module lr_resv #(
  parameter int LINE_W     = 25,
  parameter int OWNER_W    = 4,
  parameter int DATA_W     = 128,
  parameter int BEATS      = 8,
  parameter int LINE_BYTES = 128,
  localparam int IDX_W     = $clog2(BEATS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int BW        = LINE_W + OFF_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_acc,
  input  logic               cs_acc,
  input  logic               us_acc,
  input  logic [OWNER_W-1:0] req_owner,
  input  logic [LINE_W-1:0]  req_line,
  input  logic               inv_valid,
  input  logic [LINE_W-1:0]  inv_line,
  input  logic               cap_en,
  input  logic [IDX_W-1:0]   cap_idx,
  input  logic [DATA_W-1:0]  cap_data,
  input  logic [IDX_W-1:0]   cmp_idx,
  output logic               resv_valid,
  output logic               cs_owned,
  output logic               cs_ok,
  output logic [DATA_W-1:0]  cmp_data
);
  logic [OWNER_W-1:0] resv_owner;
  logic [LINE_W-1:0]  resv_line;
  logic [DATA_W-1:0]  copy_q [BEATS];

  function automatic logic [BW-1:0] byte_base(input logic [LINE_W-1:0] ln);
    return {1'b0, ln, {OFF_W{1'b0}}};
  endfunction

  function automatic logic ranges_overlap(input logic [LINE_W-1:0] a,
                                          input logic [LINE_W-1:0] b);
    logic [BW-1:0] ba, bb;
    ba = byte_base(a);
    bb = byte_base(b);
    return (ba < bb + BW'(LINE_BYTES)) && (bb < ba + BW'(LINE_BYTES));
  endfunction

  logic us_hit, inv_hit, drop;

  assign cs_owned = resv_valid && (resv_owner == req_owner);
  assign cs_ok    = cs_owned && (resv_line == req_line);
  assign us_hit   = us_acc && resv_valid && ranges_overlap(req_line, resv_line);
  assign inv_hit  = inv_valid && resv_valid && (inv_line == resv_line);
  assign drop     = (cs_acc && cs_owned) || us_hit || inv_hit;
  assign cmp_data = copy_q[cmp_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_owner <= '0;
      resv_line  <= '0;
    end else if (ld_acc) begin
      resv_valid <= 1'b1;
      resv_owner <= req_owner;
      resv_line  <= req_line;
    end else if (drop) begin
      resv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BEATS; b++) copy_q[b] <= '0;
    end else if (cap_en) begin
      copy_q[cap_idx] <= cap_data;
    end
  end

  a_r2_load_records: assert property (@(posedge clk) disable iff (!rst_n)
    ld_acc |=> resv_valid && resv_line == $past(req_line) && resv_owner == $past(req_owner));
  a_r5_owned_cond_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_acc && cs_owned) |=> !resv_valid);
  a_r7_overlap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (us_acc && resv_valid && req_line == resv_line) |=> !resv_valid);
  a_r9_invalidate_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && resv_valid && inv_line == resv_line && !ld_acc) |=> !resv_valid);
endmodule

// File: rtl/lr_beat_seq.sv
module lr_beat_seq #(
  parameter int BEATS = 8,
  localparam int IDX_W = $clog2(BEATS),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd,
  input  logic             start_wr,
  output logic             idle,
  output logic             rd_issue,
  output logic             wr_issue,
  output logic [IDX_W-1:0] cnt,
  output logic             wr_last,
  output logic             rd_pend,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_last
);
  import lr_pkg::*;
  lr_seq_e state;

  assign idle     = (state == SQ_IDLE);
  assign rd_issue = (state == SQ_RD);
  assign wr_issue = (state == SQ_WR);
  assign wr_last  = wr_issue && (cnt == LAST);
  assign rd_last  = rd_pend && (rd_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      rd_pend <= 1'b0;
      rd_idx  <= '0;
    end else begin
      rd_pend <= rd_issue;
      rd_idx  <= cnt;
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (start_rd) state <= SQ_RD;
          else if (start_wr) state <= SQ_WR;
        end
        SQ_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= SQ_RDWAIT;
        end
        SQ_RDWAIT: state <= SQ_IDLE;
        SQ_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  a_r1_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue || wr_issue) && cnt != LAST |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/lr_stat_chan.sv
module lr_stat_chan #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CODE_W-1:0] push_code,
  input  logic              pop,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      code  <= push_code;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end

  a_r8_push_overwrites: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> valid && code == $past(push_code));
  a_r10_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> !valid);
  a_r10_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !push) |=> !valid);
endmodule

// File: rtl/lockline_resv_unit.sv
module lockline_resv_unit #(
  parameter int LINE_W     = 25,
  parameter int OWNER_W    = 4,
  parameter int DATA_W     = 128,
  parameter int BEATS      = 8,
  parameter int LINE_BYTES = 128,
  localparam int IDX_W     = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [OWNER_W-1:0] cmd_owner,
  input  logic [LINE_W-1:0]  cmd_line,
  output logic [IDX_W-1:0]   st_idx,
  input  logic [DATA_W-1:0]  st_data,
  output logic               ld_valid,
  output logic [IDX_W-1:0]   ld_idx,
  output logic [DATA_W-1:0]  ld_data,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LINE_W+IDX_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               inv_valid,
  input  logic [LINE_W-1:0]  inv_line,
  input  logic               stat_pop,
  output logic               stat_valid,
  output logic [1:0]         stat_code
);
  import lr_pkg::*;

  lr_op_e op;
  logic acc, ld_acc, cs_acc, us_acc;
  logic idle, rd_issue, wr_issue, wr_last, rd_pend, rd_last;
  logic [IDX_W-1:0] cnt, rd_idx;
  logic resv_valid, cs_owned, cs_ok;
  logic [DATA_W-1:0] cmp_data;
  logic cur_cond, cur_load;
  logic [LINE_W-1:0] cur_line;
  logic cs_fail, push;
  lr_code_e push_code;
  logic beat_same;

  assign op        = lr_op_e'(cmd_op);
  assign cmd_ready = idle;
  assign acc       = cmd_valid && idle;
  assign ld_acc    = acc && (op == OP_LOAD_RSV);
  assign cs_acc    = acc && (op == OP_STORE_COND);
  assign us_acc    = acc && (op == OP_STORE_ANY);
  assign cs_fail   = cs_acc && !cs_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_cond <= 1'b0;
      cur_load <= 1'b0;
      cur_line <= '0;
    end else if (acc) begin
      cur_cond <= (op == OP_STORE_COND);
      cur_load <= (op == OP_LOAD_RSV);
      cur_line <= cmd_line;
    end
  end

  lr_resv #(
    .LINE_W(LINE_W), .OWNER_W(OWNER_W), .DATA_W(DATA_W),
    .BEATS(BEATS), .LINE_BYTES(LINE_BYTES)
  ) resv_i (
    .clk(clk), .rst_n(rst_n),
    .ld_acc(ld_acc), .cs_acc(cs_acc), .us_acc(us_acc),
    .req_owner(cmd_owner), .req_line(cmd_line),
    .inv_valid(inv_valid), .inv_line(inv_line),
    .cap_en(rd_pend && cur_load), .cap_idx(rd_idx), .cap_data(mem_rdata),
    .cmp_idx(cnt),
    .resv_valid(resv_valid), .cs_owned(cs_owned), .cs_ok(cs_ok),
    .cmp_data(cmp_data)
  );

  lr_beat_seq #(.BEATS(BEATS)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start_rd(ld_acc),
    .start_wr(us_acc || (cs_acc && cs_ok)),
    .idle(idle), .rd_issue(rd_issue), .wr_issue(wr_issue), .cnt(cnt),
    .wr_last(wr_last), .rd_pend(rd_pend), .rd_idx(rd_idx), .rd_last(rd_last)
  );

  assign beat_same = cur_cond && (st_data == cmp_data);
  assign st_idx    = cnt;
  assign mem_req   = rd_issue || (wr_issue && !beat_same);
  assign mem_we    = wr_issue;
  assign mem_addr  = {cur_line, cnt};
  assign mem_wdata = st_data;
  assign ld_valid  = rd_pend;
  assign ld_idx    = rd_idx;
  assign ld_data   = mem_rdata;

  assign push = cs_fail || wr_last || rd_last;
  always_comb begin
    if (cs_fail)       push_code = RC_COND_FAIL;
    else if (rd_last)  push_code = RC_GET_OK;
    else if (cur_cond) push_code = RC_COND_OK;
    else               push_code = RC_ANY_OK;
  end

  lr_stat_chan #(.CODE_W(2)) stat_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_code(push_code), .pop(stat_pop),
    .valid(stat_valid), .code(stat_code)
  );

  a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fail |=> !mem_req && cmd_ready);
  a_r6_any_store_all_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_issue && !cur_cond) |-> mem_req && mem_we);
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue || wr_issue) |-> !cmd_ready);
endmodule

// File: tb/lockline_resv_unit_tb_top.sv
module lockline_resv_unit_tb_top;
  localparam int LW = 25;
  localparam int OW = 4;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [OW-1:0] cmd_owner = '0;
  logic [LW-1:0] cmd_line = '0;
  logic [2:0] st_idx;
  logic [DW-1:0] st_data;
  logic ld_valid;
  logic [2:0] ld_idx;
  logic [DW-1:0] ld_data;
  logic mem_req, mem_we;
  logic [LW+2:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic inv_valid = 1'b0;
  logic [LW-1:0] inv_line = '0;
  logic stat_pop = 1'b0, stat_valid;
  logic [1:0] stat_code;

  lockline_resv_unit dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  logic [DW-1:0] mem  [128];
  logic [DW-1:0] emem [128];
  logic [DW-1:0] sbuf [8];
  logic [DW-1:0] lbuf [8];
  int wr_cnt = 0, rd_cnt = 0, ord_err = 0, ld_next = 0;

  assign st_data = sbuf[st_idx];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin mem[mem_addr[6:0]] <= mem_wdata; wr_cnt++; end
      else begin mem_rdata <= mem[mem_addr[6:0]]; rd_cnt++; end
    end
  end

  always @(negedge clk) begin
    if (ld_valid) begin
      if (int'(ld_idx) != ld_next) ord_err++;
      lbuf[ld_idx] = ld_data;
      ld_next++;
    end
  end

  // reference reservation state
  bit rv = 0;
  int rown = 0, rline = 0;
  logic [DW-1:0] rdat [8];

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic int exp_code(input int op, input int own, input int line);
    if (op == 0) return 0;
    if (op == 2) return 3;
    return (rv && own == rown && line == rline) ? 1 : 2;
  endfunction

  task automatic inv_pulse(input int line);
    @(negedge clk);
    inv_valid = 1'b1; inv_line = LW'(line);
    @(negedge clk);
    inv_valid = 1'b0;
    if (rv && line == rline) rv = 0;
  endtask

  task automatic run_cmd(input int op, input int own, input int line, input bit pop,
                         input bit inv_same, input string rq);
    int ec, ewr, wr0, rd0, bad_beats;
    bit has_code;
    ec = exp_code(op, own, line);
    has_code = (op != 3);
    ewr = 0;
    if (op == 0) begin
      for (int b = 0; b < 8; b++) rdat[b] = emem[line*8+b];
      rv = 1; rown = own; rline = line;
    end else if (op == 1) begin
      if (ec == 1) begin
        for (int b = 0; b < 8; b++)
          if (sbuf[b] != rdat[b]) begin ewr++; emem[line*8+b] = sbuf[b]; end
      end
      if (rv && own == rown) rv = 0;
    end else if (op == 2) begin
      ewr = 8;
      for (int b = 0; b < 8; b++) emem[line*8+b] = sbuf[b];
      if (rv && line == rline) rv = 0;
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    wr0 = wr_cnt; rd0 = rd_cnt; ld_next = 0;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_owner = OW'(own); cmd_line = LW'(line);
    if (inv_same) begin inv_valid = 1'b1; inv_line = LW'(line); end
    @(negedge clk);
    cmd_valid = 1'b0; inv_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    if (has_code) begin
      chk(stat_valid === 1'b1, {rq, " R8 code present"}, DW'(stat_valid), 1);
      chk(stat_code === 2'(ec), {rq, " code"}, DW'(stat_code), DW'(ec));
    end else begin
      chk(stat_valid === 1'b0, {rq, " R11 no-op pushes nothing"}, DW'(stat_valid), 0);
    end
    if (op == 0) begin
      bad_beats = 0;
      for (int b = 0; b < 8; b++) if (lbuf[b] !== rdat[b]) bad_beats++;
      chk(bad_beats == 0 && ord_err == 0 && ld_next == 8, {rq, " R2 R1 load beats"},
          DW'(bad_beats + ord_err), 0);
      chk(rd_cnt - rd0 == 8, {rq, " R1 read beats"}, DW'(rd_cnt - rd0), 8);
    end else begin
      chk(wr_cnt - wr0 == ewr, {rq, " write count"}, DW'(wr_cnt - wr0), DW'(ewr));
      bad_beats = 0;
      for (int b = 0; b < 8; b++) if (mem[line*8+b] !== emem[line*8+b]) bad_beats++;
      chk(bad_beats == 0, {rq, " memory line"}, DW'(bad_beats), 0);
    end
    if (pop && has_code) begin
      stat_pop = 1'b1;
      @(negedge clk);
      stat_pop = 1'b0;
      chk(stat_valid === 1'b0, {rq, " R10 pop empties"}, DW'(stat_valid), 0);
    end
  endtask

  task automatic fill_sbuf_rand();
    for (int b = 0; b < 8; b++) sbuf[b] = rnd128();
  endtask

  task automatic fill_sbuf_resv(input int nchg);
    for (int b = 0; b < 8; b++) sbuf[b] = rdat[b];
    for (int k = 0; k < nchg; k++) sbuf[k*3 % 8] = ~rdat[k*3 % 8];
  endtask

  initial begin
    #(4*200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    for (int i = 0; i < 128; i++) begin mem[i] = rnd128(); emem[i] = mem[i]; end
    for (int b = 0; b < 8; b++) sbuf[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R11 reset ready", DW'(cmd_ready), 1);
    chk(stat_valid === 1'b0, "R10 reset empty", DW'(stat_valid), 0);
    chk(mem_req === 1'b0, "R1 reset idle port", DW'(mem_req), 0);
    stat_pop = 1'b1; @(negedge clk); stat_pop = 1'b0; @(negedge clk);
    chk(stat_valid === 1'b0, "R10 pop on empty", DW'(stat_valid), 0);

    // R3 unchanged data: success, zero writes; R5 then repeat fails
    run_cmd(0, 1, 2, 1, 0, "R2 load");
    fill_sbuf_resv(0);
    run_cmd(1, 1, 2, 1, 0, "R3 cond unchanged");
    run_cmd(1, 1, 2, 1, 0, "R5 cond after clear");
    // R5 non-owner keeps; R3 partial write
    run_cmd(0, 1, 2, 1, 0, "R2 reload");
    fill_sbuf_resv(2);
    run_cmd(1, 2, 2, 1, 0, "R4 R5 non-owner");
    run_cmd(1, 1, 2, 1, 0, "R3 two beats changed");
    // R5 owner wrong line clears
    run_cmd(0, 1, 3, 1, 0, "R2 load line3");
    fill_sbuf_resv(1);
    run_cmd(1, 1, 1, 1, 0, "R4 wrong line");
    run_cmd(1, 1, 3, 1, 0, "R5 cleared by owner fail");
    // R7
    run_cmd(0, 0, 1, 1, 0, "R2 load line1");
    fill_sbuf_rand();
    run_cmd(2, 3, 0, 1, 0, "R6 store other line");
    fill_sbuf_resv(1);
    run_cmd(1, 0, 1, 1, 0, "R7 survives other line");
    run_cmd(0, 0, 1, 1, 0, "R2 load line1 again");
    fill_sbuf_rand();
    run_cmd(2, 3, 1, 1, 0, "R6 store same line");
    fill_sbuf_resv(1);
    run_cmd(1, 0, 1, 1, 0, "R7 cleared by overlap");
    // R9
    run_cmd(0, 2, 0, 1, 0, "R2 load line0");
    inv_pulse(2);
    fill_sbuf_resv(1);
    run_cmd(1, 2, 0, 1, 0, "R9 other-line invalidate");
    run_cmd(0, 2, 0, 1, 0, "R2 load line0 again");
    inv_pulse(0);
    fill_sbuf_resv(1);
    run_cmd(1, 2, 0, 1, 0, "R9 invalidate clears");
    run_cmd(0, 2, 3, 1, 1, "R9 load with same-cycle invalidate");
    fill_sbuf_resv(1);
    run_cmd(1, 2, 3, 1, 0, "R9 load wins");
    // R8 overwrite
    run_cmd(0, 1, 1, 0, 0, "R8 first code");
    fill_sbuf_rand();
    run_cmd(2, 1, 2, 1, 0, "R8 overwritten by store");
    // R11
    run_cmd(3, 1, 1, 1, 0, "R11 no-op");
    run_cmd(0, 1, 0, 1, 0, "R11 first load");
    run_cmd(0, 2, 1, 1, 0, "R11 replacing load");
    fill_sbuf_resv(1);
    run_cmd(1, 1, 0, 1, 0, "R11 old reservation gone");

    for (int it = 0; it < 150; it++) begin
      int op, own, line;
      op = int'($urandom % 5); own = int'($urandom % 3); line = int'($urandom % 4);
      if (op == 4) inv_pulse(line);
      else begin
        if (op == 1 && ($urandom % 2) == 1) fill_sbuf_resv(int'($urandom % 3));
        else fill_sbuf_rand();
        if (op == 3) op = 1;
        run_cmd(op, own, line, 1, 0, "R3 R4 R7 random");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule